// File: doc/BRIEF.md
# Paged Program Sequencer with One-Level Call

This block generates instruction fetch addresses for a program store of 1024 eight-bit words. The store is split into 16 pages of 64 words. The fetch address is a 4-bit page number joined to a 6-bit in-page offset. Once per instruction cycle, on the cycle strobe, the sequencer does one of two things. It moves the offset to the next word, or it carries out one decoded control instruction.

Changing page takes two steps. First, a load-page-buffer instruction stages a 4-bit constant in a page buffer; the page in use does not change. Then a taken branch or call copies the buffer into the current page and loads the 6-bit target into the offset. A branch or call is taken only while the status input is one. With status zero it behaves as a plain step.

A call also does two more things: it saves the offset of the next word in a one-entry return register, and it swaps the old page into the page buffer. A return then restores both the page and the offset. Only one return level exists. The decoded action is a small enumerated set: STEP, LOAD_PAGE (`ACT_LDPB`), JUMP, CALL and RETURN. The action is chosen by a fixed priority, and each action moves the registers exactly as the requirements below describe.

Top module: `paged_seq`

## Requirements
- R1: While power-on reset (`rst_n` low) is held, and on its release, the fetch address is page 15, offset 0 (value 960). The page buffer also starts at 15, so a taken branch before any buffer load stays on page 15.
- R2: On a strobe with no control asserted (STEP), the offset increases by one and the page is unchanged.
- R3: On a strobe with only `ldpb` asserted (LOAD_PAGE), the page buffer takes `konst`. The current page is unchanged and the offset increases by one.
- R4: On a strobe with `br` asserted and `status` = 1 (JUMP), the page becomes the page buffer value and the offset becomes `target`.
- R5: With `status` = 0, a strobe with `br` or `call` acts as STEP. No page changes and no return offset is saved.
- R6: On a strobe with `call` asserted and `status` = 1 (CALL), three things happen: the offset of the next word (current offset plus one, modulo 64) is saved, the old page moves into the page buffer, and the page and offset load as for a taken branch.
- R7: On a strobe with `ret` asserted (RETURN), the page becomes the page buffer value and the offset becomes the saved return offset, whatever `status` is.
- R8: With `cyc_stb` low, no register changes, whatever the other inputs are.
- R9: Offset 63 steps to offset 0 on the same page. A call from offset 63 saves a return offset of 0.
- R10: A second taken call before a return overwrites the saved return offset.
- R11: When several controls are asserted together, the priority is `ret` over a taken `call` over a taken `br` over `ldpb`. The losing controls have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cyc_stb | input | 1 | One-clock strobe marking the end of an instruction cycle |
| br | input | 1 | Decoded branch instruction |
| call | input | 1 | Decoded call instruction |
| ret | input | 1 | Decoded return instruction |
| ldpb | input | 1 | Decoded load-page-buffer instruction |
| target | input | 6 | In-page target offset for branch or call |
| konst | input | 4 | Constant for the page buffer |
| status | input | 1 | Status bit; one enables branch and call |
| fetch_addr | output | 10 | Fetch address, {page, offset} |

## Verification
Every result is registered, so each strobe's effect appears on `fetch_addr` after exactly one rising edge. The bench drives a strobe at a falling edge and samples at the next falling edge, half a period after the register update. State that is not on a port is made visible through the next action: the page buffer shows up after a later taken branch, and the return offset shows up after a later return. Each of these is checked one strobe after the action that exposes it. The no-strobe case is checked by holding controls active for several cycles with the strobe low.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Decoded action for one instruction cycle
    typedef enum logic [2:0] {
        ACT_STEP = 3'd0,
        ACT_LDPB = 3'd1,
        ACT_JUMP = 3'd2,
        ACT_CALL = 3'd3,
        ACT_RET  = 3'd4
    } seq_act_e;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cyc_stb,
    input  logic     br,
    input  logic     call,
    input  logic     ret,
    input  logic     ldpb,
    input  logic     status,
    output seq_act_e act
);

    // Fixed priority: return, taken call, taken branch, buffer load
    always_comb begin
        if (ret)                 act = ACT_RET;
        else if (call && status) act = ACT_CALL;
        else if (br && status)   act = ACT_JUMP;
        else if (ldpb)           act = ACT_LDPB;
        else                     act = ACT_STEP;
    end

    AST_UNTAKEN_IS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !status && !ret && !ldpb) |-> act == ACT_STEP); // R5

    AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && ret) |-> act == ACT_RET); // R11

endmodule

// File: rtl/page_regs.sv
module page_regs
    import seq_pkg::*;
#(
    parameter int unsigned PAGE_W     = 4,
    parameter int unsigned RESET_PAGE = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  seq_act_e          act,
    input  logic [PAGE_W-1:0] konst,
    output logic [PAGE_W-1:0] page_q,
    output logic [PAGE_W-1:0] pbuf_q
);

    localparam logic [PAGE_W-1:0] START_PAGE = PAGE_W'(RESET_PAGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= START_PAGE;
            pbuf_q <= START_PAGE;
        end else if (cyc_stb) begin
            unique case (act)
                ACT_STEP: ;
                ACT_LDPB: pbuf_q <= konst;
                ACT_JUMP: page_q <= pbuf_q;
                ACT_CALL: begin
                    page_q <= pbuf_q;
                    pbuf_q <= page_q;
                end
                ACT_RET:  page_q <= pbuf_q;
                default:  ;
            endcase
        end
    end

    AST_LDPB_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && act == ACT_LDPB) |=> $stable(page_q)); // R3

    AST_STEP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && act == ACT_STEP) |=> ($stable(page_q) && $stable(pbuf_q))); // R2

    AST_IDLE_HOLDS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> ($stable(page_q) && $stable(pbuf_q))); // R8

    AST_CALL_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && act == ACT_CALL) |=> (pbuf_q == $past(page_q))); // R6

endmodule

// File: rtl/offset_ctr.sv
module offset_ctr
    import seq_pkg::*;
#(
    parameter int unsigned OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb,
    input  seq_act_e         act,
    input  logic [OFF_W-1:0] target,
    output logic [OFF_W-1:0] off_q
);

    localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};

    logic [OFF_W-1:0] ret_q;
    logic [OFF_W-1:0] off_next;

    assign off_next = off_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            ret_q <= '0;
        end else if (cyc_stb) begin
            unique case (act)
                ACT_STEP, ACT_LDPB: off_q <= off_next;
                ACT_JUMP: off_q <= target;
                ACT_CALL: begin
                    ret_q <= off_next;
                    off_q <= target;
                end
                ACT_RET:  off_q <= ret_q;
                default:  ;
            endcase
        end
    end

    AST_STEP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && (act == ACT_STEP || act == ACT_LDPB)) |=>
        (off_q == OFF_W'($past(off_q) + 1'b1))); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && act == ACT_STEP && off_q == OFF_LAST) |=> (off_q == '0)); // R9

    AST_CALL_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && act == ACT_CALL) |=> (ret_q == OFF_W'($past(off_q) + 1'b1))); // R6

    AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && act == ACT_RET) |=> (off_q == $past(ret_q))); // R7

    AST_IDLE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> ($stable(off_q) && $stable(ret_q))); // R8

endmodule

// File: rtl/paged_seq.sv
module paged_seq
    import seq_pkg::*;
#(
    parameter int unsigned PAGE_W     = 4,
    parameter int unsigned OFF_W      = 6,
    parameter int unsigned RESET_PAGE = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cyc_stb,
    input  logic                    br,
    input  logic                    call,
    input  logic                    ret,
    input  logic                    ldpb,
    input  logic [OFF_W-1:0]        target,
    input  logic [PAGE_W-1:0]       konst,
    input  logic                    status,
    output logic [PAGE_W+OFF_W-1:0] fetch_addr
);

    localparam int unsigned ADDR_W = PAGE_W + OFF_W;
    localparam logic [ADDR_W-1:0] START_ADDR = {PAGE_W'(RESET_PAGE), {OFF_W{1'b0}}};

    seq_act_e          act;
    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] pbuf_q;
    logic [OFF_W-1:0]  off_q;

    seq_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb),
        .br      (br),
        .call    (call),
        .ret     (ret),
        .ldpb    (ldpb),
        .status  (status),
        .act     (act)
    );

    page_regs #(
        .PAGE_W     (PAGE_W),
        .RESET_PAGE (RESET_PAGE)
    ) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb),
        .act     (act),
        .konst   (konst),
        .page_q  (page_q),
        .pbuf_q  (pbuf_q)
    );

    offset_ctr #(
        .OFF_W (OFF_W)
    ) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb),
        .act     (act),
        .target  (target),
        .off_q   (off_q)
    );

    assign fetch_addr = {page_q, off_q};

    AST_RESET_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_addr == START_ADDR)); // R1

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && status && (br || call) && !ret) |=>
        (fetch_addr == {$past(pbuf_q), $past(target)})); // R4

endmodule

// File: tb/paged_seq_test.sv
module paged_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       br = 1'b0;
    logic       call = 1'b0;
    logic       ret = 1'b0;
    logic       ldpb = 1'b0;
    logic [5:0] target = '0;
    logic [3:0] konst = '0;
    logic       status = 1'b0;
    logic [9:0] fetch_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    paged_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_stb    (cyc_stb),
        .br         (br),
        .call       (call),
        .ret        (ret),
        .ldpb       (ldpb),
        .target     (target),
        .konst      (konst),
        .status     (status),
        .fetch_addr (fetch_addr)
    );

    // {req[3:0], ctl{ret,call,br,ldpb}, status, target[5:0], konst[3:0], expected[9:0]}
    localparam int NV = 19;
    localparam logic [28:0] VEC [NV] = '{
        {4'd2,  4'b0000, 1'b0, 6'd0,  4'd0,  10'd961}, // R2 step
        {4'd3,  4'b0001, 1'b0, 6'd0,  4'd3,  10'd962}, // R3 load buffer=3
        {4'd5,  4'b0010, 1'b0, 6'd10, 4'd0,  10'd963}, // R5 branch not taken
        {4'd4,  4'b0010, 1'b1, 6'd10, 4'd0,  10'd202}, // R4 branch to 3:10
        {4'd3,  4'b0001, 1'b0, 6'd0,  4'd7,  10'd203}, // R3 load buffer=7
        {4'd6,  4'b0100, 1'b1, 6'd20, 4'd0,  10'd468}, // R6 call to 7:20
        {4'd2,  4'b0000, 1'b0, 6'd0,  4'd0,  10'd469}, // R2 step in subroutine
        {4'd7,  4'b1000, 1'b0, 6'd0,  4'd0,  10'd204}, // R7 return, status 0
        {4'd5,  4'b0100, 1'b0, 6'd5,  4'd0,  10'd205}, // R5 call not taken
        {4'd5,  4'b1000, 1'b1, 6'd0,  4'd0,  10'd204}, // R5 untaken call saved nothing
        {4'd11, 4'b0011, 1'b1, 6'd40, 4'd9,  10'd232}, // R11 branch beats load
        {4'd11, 4'b0010, 1'b1, 6'd62, 4'd0,  10'd254}, // R11 buffer still 3
        {4'd2,  4'b0000, 1'b0, 6'd0,  4'd0,  10'd255}, // R2 reach 63
        {4'd9,  4'b0000, 1'b0, 6'd0,  4'd0,  10'd192}, // R9 wrap to 0
        {4'd3,  4'b0001, 1'b0, 6'd0,  4'd12, 10'd193}, // R3 load buffer=12
        {4'd6,  4'b0100, 1'b1, 6'd7,  4'd0,  10'd775}, // R6 call to 12:7
        {4'd10, 4'b0100, 1'b1, 6'd30, 4'd0,  10'd222}, // R10 second call
        {4'd10, 4'b1000, 1'b1, 6'd0,  4'd0,  10'd776}, // R10 return to 12:8
        {4'd11, 4'b1110, 1'b1, 6'd1,  4'd0,  10'd776}  // R11 return wins
    };

    task automatic check(input int req, input logic [9:0] got, input logic [9:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: fetch_addr=%0d expected %0d", req, got, exp);
        end
    endtask

    task automatic strobe(input logic [3:0] ctl, input logic st,
                          input logic [5:0] tg, input logic [3:0] k);
        @(negedge clk);
        {ret, call, br, ldpb} = ctl;
        status  = st;
        target  = tg;
        konst   = k;
        cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0;
        {ret, call, br, ldpb} = 4'b0000;
        status  = 1'b0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, fetch_addr, 10'd960); // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, fetch_addr, 10'd960); // R1 after release

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][24:21], VEC[i][20], VEC[i][19:14], VEC[i][13:10]);
            check(int'(VEC[i][28:25]), fetch_addr, VEC[i][9:0]);
        end

        // R8: controls active, strobe low, nothing moves
        {ret, call, br, ldpb} = 4'b1111;
        status = 1'b1;
        target = 6'd9;
        konst  = 4'd1;
        repeat (4) @(negedge clk);
        check(8, fetch_addr, 10'd776);
        {ret, call, br, ldpb} = 4'b0000;
        strobe(4'b0010, 1'b1, 6'd3, 4'd0); // buffer untouched: still 12
        check(8, fetch_addr, 10'd771);

        // R1: reset mid-run, buffer back at 15
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, fetch_addr, 10'd960);
        rst_n = 1'b1;
        strobe(4'b0010, 1'b1, 6'd5, 4'd0);
        check(1, fetch_addr, 10'd965);

        // R9: call from offset 63 saves return offset 0
        strobe(4'b0010, 1'b1, 6'd63, 4'd0);
        check(9, fetch_addr, 10'd1023);
        strobe(4'b0100, 1'b1, 6'd2, 4'd0);
        check(6, fetch_addr, 10'd962);
        strobe(4'b1000, 1'b0, 6'd0, 4'd0);
        check(9, fetch_addr, 10'd960);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule